// File: doc/BRIEF.md
# Resolution-Programmable Temperature Conversion Sequencer

This block paces a free-running series of temperature conversions and keeps the most recent finished result in a readable 16-bit temperature register. An input port supplies raw 12-bit two's-complement samples and stands in for the analog front end. Time is measured in prescaled ticks. A conversion at the coarsest setting lasts `BASE_TICKS` ticks, and each extra bit of resolution doubles that length. A single-cycle done strobe marks every register update, so the downstream thermostat comparator evaluates each result once.

The register format is sign in bit 15, integer degrees in bits 14:8 and a binary fraction in bits 7:4. Bits 3:0 are always zero. Result bits finer than the active resolution are cleared when the result is stored. A shutdown input stops new conversions. The conversion already in progress is still finished and stored. When shutdown is released, a fresh conversion begins on the next tick. `BASE_TICKS` must be at least 2.

Top module: `temp_conv_seq`

## Requirements
- R1: While `rst` is high and after it is released, `temp_o` reads 0 and `done_o` reads 0 until the first conversion completes. The first conversion starts on the first tick after reset. It completes `BASE_TICKS << res` ticks later, so with `res_i`=00 the first strobe follows the (1+`BASE_TICKS`)-th tick.
- R2: Resolution code `res_i` selects 9, 10, 11 or 12 bits for codes 00, 01, 10 and 11. The conversion length is `BASE_TICKS << code` ticks. Cycles without `tick_i` do not advance a conversion.
- R3: On completion, `temp_o[15:4]` takes `sample_i` as present in the completing tick's cycle, and `temp_o[3:0]` is 0. Only the top 9+code bits are kept and the rest read 0, which gives a mask of FF80, FFC0, FFE0 or FFF0 for codes 00 to 11.
- R4: With shutdown low, the next conversion starts on the completing tick itself, so strobes recur exactly every `BASE_TICKS << code` ticks.
- R5: `res_i` is sampled only when a conversion starts. A change made mid-conversion first affects the length and masking of the following conversion.
- R6: If `shutdown_i` is high on the completing tick, that result is still stored and strobed. No further conversion starts, and `temp_o` holds regardless of `sample_i`.
- R7: When `shutdown_i` returns low in standby, the next tick starts a conversion that completes `BASE_TICKS << code` ticks later.
- R8: `done_o` is high for exactly one cycle per stored result, in the same cycle `temp_o` first shows that result. `temp_o` does not change in any cycle where `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaled time-base tick, one cycle wide |
| shutdown_i | input | 1 | Stop after the running conversion |
| res_i | input | 2 | Resolution code (00=9 bit ... 11=12 bit) |
| sample_i | input | 12 | Raw two's-complement sample from the front end |
| temp_o | output | 16 | Last completed temperature result |
| done_o | output | 1 | One-cycle strobe on each result update |

## Verification
The tick counter, the latched resolution and the idle/converting state are all visible only through when `done_o` fires and what `temp_o` holds. A counter that is off by one shows up as a strobe one tick early or late in the very next conversion. A resolution latched at the wrong moment changes both the strobe spacing and the cleared low bits of the following result. A state that mishandles shutdown shows up either as a missing final result or as strobes and register changes during a long standby window, within one conversion period.

// File: rtl/temp_seq_pkg.sv
`timescale 1ns/1ps
package temp_seq_pkg;
  localparam int SMP_W  = 12;
  localparam int TEMP_W = SMP_W + 4;
  localparam int RES_W  = 2;

  typedef enum logic {ST_IDLE, ST_CONV} seq_state_e;

  // keep the top (SMP_W-3+code) bits of the result, i.e. 9..12 bits
  function automatic logic [TEMP_W-1:0] res_mask(input logic [RES_W-1:0] code);
    return {TEMP_W{1'b1}} << (TEMP_W - (SMP_W - 3 + int'(code)));
  endfunction
endpackage

// File: rtl/conv_seq_ctrl.sv
`timescale 1ns/1ps
module conv_seq_ctrl
  import temp_seq_pkg::*;
#(
  parameter int BASE_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             shutdown_i,
  input  logic [RES_W-1:0] res_i,
  output logic             finish_o,
  output logic [RES_W-1:0] res_q_o
);
  localparam int MAX_P = BASE_TICKS << ((1 << RES_W) - 1);
  localparam int CNT_W = $clog2(MAX_P + 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic [RES_W-1:0] res_q;
  logic             last;

  assign period   = CNT_W'(BASE_TICKS) << res_q;
  assign last     = (cnt == period - 1'b1);
  assign finish_o = (state == ST_CONV) && tick_i && last;
  assign res_q_o  = res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      res_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (tick_i && !shutdown_i) begin
            state <= ST_CONV;
            cnt   <= '0;
            res_q <= res_i;
          end
        end
        default: begin
          if (tick_i) begin
            if (last) begin
              cnt <= '0;
              if (shutdown_i) state <= ST_IDLE;
              else            res_q <= res_i;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV) |-> (cnt < period));

  // R5
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV && !finish_o) |=> $stable(res_q));

  // R6
  standby_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && shutdown_i) |=> (state == ST_IDLE));
endmodule

// File: rtl/conv_result_reg.sv
`timescale 1ns/1ps
module conv_result_reg
  import temp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic [SMP_W-1:0]  sample_i,
  output logic [TEMP_W-1:0] temp_o,
  output logic              done_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      temp_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) temp_o <= {sample_i, 4'b0000} & res_mask(res_i);
    end
  end

  // R3
  lsb_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((temp_o & ~res_mask($past(res_i))) == '0));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  temp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(temp_o));
endmodule

// File: rtl/temp_conv_seq.sv
`timescale 1ns/1ps
module temp_conv_seq
  import temp_seq_pkg::*;
#(
  parameter int BASE_TICKS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_i,
  input  logic        shutdown_i,
  input  logic [1:0]  res_i,
  input  logic [11:0] sample_i,
  output logic [15:0] temp_o,
  output logic        done_o
);
  logic             finish;
  logic [RES_W-1:0] res_act;

  conv_seq_ctrl #(.BASE_TICKS(BASE_TICKS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .shutdown_i (shutdown_i),
    .res_i      (res_i),
    .finish_o   (finish),
    .res_q_o    (res_act)
  );

  conv_result_reg u_res (
    .clk      (clk),
    .rst      (rst),
    .load_i   (finish),
    .res_i    (res_act),
    .sample_i (sample_i),
    .temp_o   (temp_o),
    .done_o   (done_o)
  );

  // R2
  done_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(tick_i));
endmodule

// File: tb/tb_temp_conv_seq.sv
`timescale 1ns/1ps
module tb_temp_conv_seq;
  localparam int BT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        shutdown_i = 1'b0;
  logic [1:0]  res_i = 2'b00;
  logic [11:0] sample_i = '0;
  logic [15:0] temp_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  temp_conv_seq #(.BASE_TICKS(BT)) dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .shutdown_i(shutdown_i),
    .res_i(res_i), .sample_i(sample_i), .temp_o(temp_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue ticks (each followed by an idle cycle) until done_o is seen
  task automatic go_until_done(input int maxt, output int n);
    logic [15:0] prev;
    n = -1;
    prev = temp_o;
    for (int i = 1; i <= maxt; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
      if (done_o) begin n = i; break; end
      if (temp_o !== prev) chk(0, "R8 temp changed without done", temp_o, prev);
    end
    if (n > 0) begin
      @(negedge clk);
      chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    end
  endtask

  task automatic run_ticks(input int cnt, output int dones);
    dones = 0;
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
      if (done_o) dones++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(temp_o == 16'h0 && done_o == 1'b0, "R1 reset state", temp_o, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0 && temp_o == 16'h0, "R1 idle without tick", temp_o, 0);
  endtask

  task automatic t_first();
    int n;
    res_i = 2'b00; sample_i = 12'h7D0;
    go_until_done(20, n);
    chk(n == BT + 1, "R1 first result tick", n, BT + 1);
    chk(temp_o == 16'h7D00, "R3 first value", temp_o, 16'h7D00);
  endtask

  task automatic t_continuous();
    int n;
    sample_i = 12'hFFF;
    go_until_done(20, n);
    chk(n == BT, "R4 back-to-back period", n, BT);
    chk(temp_o == 16'hFF80, "R3 mask 9 bit", temp_o, 16'hFF80);
  endtask

  task automatic t_res_change();
    int n;
    res_i = 2'b11;
    go_until_done(80, n);
    chk(n == BT, "R5 old res until next start", n, BT);
    chk(temp_o == 16'hFF80, "R5 old mask kept", temp_o, 16'hFF80);
    res_i = 2'b01;
    go_until_done(80, n);
    chk(n == BT * 8, "R2 12 bit period", n, BT * 8);
    chk(temp_o == 16'hFFF0, "R3 mask 12 bit", temp_o, 16'hFFF0);
    res_i = 2'b10;
    go_until_done(80, n);
    chk(n == BT * 2, "R2 10 bit period", n, BT * 2);
    chk(temp_o == 16'hFFC0, "R3 mask 10 bit", temp_o, 16'hFFC0);
    res_i = 2'b00;
    go_until_done(80, n);
    chk(n == BT * 4, "R2 11 bit period", n, BT * 4);
    chk(temp_o == 16'hFFE0, "R3 mask 11 bit", temp_o, 16'hFFE0);
  endtask

  task automatic t_shutdown();
    int n, d;
    run_ticks(2, d);
    chk(d == 0, "R2 no early done", d, 0);
    shutdown_i = 1'b1; sample_i = 12'h191;
    go_until_done(20, n);
    chk(n == BT - 2, "R6 running conversion completes", n, BT - 2);
    chk(temp_o == 16'h1900, "R6 final result stored", temp_o, 16'h1900);
    sample_i = 12'h7D0;
    run_ticks(40, d);
    chk(d == 0, "R6 no conversions in standby", d, 0);
    chk(temp_o == 16'h1900, "R6 register held in standby", temp_o, 16'h1900);
  endtask

  task automatic t_resume();
    int n;
    shutdown_i = 1'b0;
    go_until_done(20, n);
    chk(n == BT + 1, "R7 restart after shutdown", n, BT + 1);
    chk(temp_o == 16'h7D00, "R7 fresh value", temp_o, 16'h7D00);
  endtask

  initial begin
    t_reset();
    t_first();
    t_continuous();
    t_res_change();
    t_shutdown();
    t_resume();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule